// File: doc/BRIEF.md
# Writeback Slot Allocator

This block hands out writeback slots to instructions that have finished executing. It keeps a window of upcoming cycles, and each cycle has a fixed number of write ports. A request with an instruction tag takes the earliest free slot. The search starts at the nearest cycle and fills its ports from port 0 upward. When every port of a cycle is taken, the search moves on to the following cycle. The window holds WIDTH x DEPTH slots in total. A request that finds no free slot anywhere in the window is reported as an overflow and is not placed.

Several requests may arrive in one clock. They are served in lane order, and each lane sees the slots that lower lanes took in the same clock. Every clock the window moves forward by one cycle. The oldest cycle is presented on the writeback outputs, and an empty cycle enters at the far end. The grant for each lane reports the cycle offset and the port. It is registered and appears after the clock edge that accepted the request. A tag granted cycle offset c appears on the writeback outputs c clock edges after its grant becomes visible.

Top module: `wb_slot_alloc`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `gnt_valid`, `gnt_overflow` and `wb_valid` are all zero, and the window is empty.
- R2: A lone request is granted the lowest cycle offset that has a free port. Within that cycle it gets the lowest free port. The cycle offset is reported on `gnt_cycle` and the port number on `gnt_port`.
- R3: Requests that arrive in the same clock are placed in lane order, lane 0 first. Each lane sees the slots taken by lower lanes in that clock.
- R4: Once all WIDTH ports of a cycle are taken, the next placement goes to port 0 of the following cycle.
- R5: The window advances by one cycle per clock. A tag granted (cycle c, port p) appears on port p of `wb_tag`, with `wb_valid[p]` high, in the cycle where the grant is visible if c = 0. Otherwise it appears c clocks later.
- R6: When none of the WIDTH x DEPTH slots is free, the lane reports `gnt_overflow`=1 and `gnt_valid`=0. No slot is consumed.
- R7: `wb_valid` is always a contiguous run of ones starting at port 0. A port that is not valid shows tag 0.
- R8: A lane with `req_valid` low gives `gnt_valid`=0 and `gnt_overflow`=0, and it consumes no slot.
- R9: Each cycle enters the window empty. After DEPTH clocks with no requests, `wb_valid` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NREQ | Per-lane request strobe |
| req_tag | input | NREQ*TAG_W | Per-lane instruction tag, lane i at bits [i*TAG_W +: TAG_W] |
| gnt_valid | output | NREQ | Lane was placed in the window |
| gnt_cycle | output | NREQ*CYC_W | Granted cycle offset per lane |
| gnt_port | output | NREQ*PORT_W | Granted port per lane |
| gnt_overflow | output | NREQ | Lane found no free slot |
| wb_valid | output | WIDTH | Occupied ports of the head cycle |
| wb_tag | output | WIDTH*TAG_W | Tags of the head cycle, port p at bits [p*TAG_W +: TAG_W] |

## Verification
The hardest state to reach is a window that is nearly or completely full while several lanes request in the same clock. In that state some lanes spill across a cycle boundary and a higher lane overflows, while the window keeps advancing. Steady traffic cannot create this, because the window frees WIDTH slots every clock. The bench therefore runs directed floods with every lane active for several clocks. It then mixes random lane masks weighted toward heavy traffic, so that partially full windows keep meeting multi-lane bursts.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
  // Bits needed to index n items, never less than one.
  function automatic int wbs_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wbs_find.sv
module wbs_find #(
  parameter int WIDTH  = 2,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 2,
  parameter int CYC_W  = 2,
  parameter int PORT_W = 1
) (
  input  logic                   req,
  input  logic [DEPTH*CNT_W-1:0] cnt_in,
  output logic                   hit,
  output logic                   miss,
  output logic [CYC_W-1:0]       cyc,
  output logic [PORT_W-1:0]      port,
  output logic [DEPTH*CNT_W-1:0] cnt_out
);
  // Scan cycles nearest-first, take the first one with a free port.
  always_comb begin
    hit     = 1'b0;
    cyc     = '0;
    port    = '0;
    cnt_out = cnt_in;
    for (int d = 0; d < DEPTH; d++) begin
      if (req && !hit && (cnt_in[d*CNT_W +: CNT_W] < CNT_W'(WIDTH))) begin
        hit  = 1'b1;
        cyc  = CYC_W'(d);
        port = PORT_W'(cnt_in[d*CNT_W +: CNT_W]);
        cnt_out[d*CNT_W +: CNT_W] = cnt_in[d*CNT_W +: CNT_W] + 1'b1;
      end
    end
  end

  assign miss = req & ~hit;
endmodule

// File: rtl/wbs_window.sv
module wbs_window #(
  parameter int WIDTH  = 2,
  parameter int DEPTH  = 4,
  parameter int NREQ   = 3,
  parameter int TAG_W  = 8,
  parameter int CNT_W  = 2,
  parameter int CYC_W  = 2,
  parameter int PORT_W = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [DEPTH*CNT_W-1:0]  cnt_fin,
  input  logic [NREQ-1:0]         wr_en,
  input  logic [NREQ*CYC_W-1:0]   wr_cyc,
  input  logic [NREQ*PORT_W-1:0]  wr_port,
  input  logic [NREQ*TAG_W-1:0]   wr_tag,
  output logic [DEPTH*CNT_W-1:0]  view_cnt,
  output logic [WIDTH-1:0]        wb_valid,
  output logic [WIDTH*TAG_W-1:0]  wb_tag
);
  logic [DEPTH*CNT_W-1:0] cnt_q;
  logic [TAG_W-1:0]       tag_q [DEPTH][WIDTH];
  logic [TAG_W-1:0]       tag_d [DEPTH][WIDTH];

  // Occupancy as seen after this edge's advance: row k takes row k+1.
  assign view_cnt = {{CNT_W{1'b0}}, cnt_q[DEPTH*CNT_W-1:CNT_W]};

  always_comb begin
    for (int k = 0; k < DEPTH-1; k++)
      for (int p = 0; p < WIDTH; p++)
        tag_d[k][p] = tag_q[k+1][p];
    for (int p = 0; p < WIDTH; p++)
      tag_d[DEPTH-1][p] = '0;
    for (int i = 0; i < NREQ; i++)
      if (wr_en[i])
        tag_d[wr_cyc[i*CYC_W +: CYC_W]][wr_port[i*PORT_W +: PORT_W]] =
          wr_tag[i*TAG_W +: TAG_W];
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_fin;
  end

  // Tag array carries no reset; occupancy counts qualify every entry.
  always_ff @(posedge clk) begin
    for (int k = 0; k < DEPTH; k++)
      for (int p = 0; p < WIDTH; p++)
        tag_q[k][p] <= tag_d[k][p];
  end

  always_comb begin
    for (int p = 0; p < WIDTH; p++) begin
      wb_valid[p] = CNT_W'(p) < cnt_q[0 +: CNT_W];
      wb_tag[p*TAG_W +: TAG_W] = wb_valid[p] ? tag_q[0][p] : '0;
    end
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_bound
      AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q[g*CNT_W +: CNT_W] <= CNT_W'(WIDTH)); // R2
    end
    for (g = 0; g < DEPTH-1; g++) begin : g_shift
      AST_SHIFT_KEEP: assert property (@(posedge clk) disable iff (rst)
        cnt_q[g*CNT_W +: CNT_W] >= $past(cnt_q[(g+1)*CNT_W +: CNT_W])); // R5
    end
  endgenerate
endmodule

// File: rtl/wb_slot_alloc.sv
module wb_slot_alloc import wbs_pkg::*; #(
  parameter int WIDTH = 2,
  parameter int DEPTH = 4,
  parameter int NREQ  = 3,
  parameter int TAG_W = 8,
  localparam int CYC_W  = wbs_bits(DEPTH),
  localparam int PORT_W = wbs_bits(WIDTH),
  localparam int CNT_W  = wbs_bits(WIDTH+1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NREQ-1:0]        req_valid,
  input  logic [NREQ*TAG_W-1:0]  req_tag,
  output logic [NREQ-1:0]        gnt_valid,
  output logic [NREQ*CYC_W-1:0]  gnt_cycle,
  output logic [NREQ*PORT_W-1:0] gnt_port,
  output logic [NREQ-1:0]        gnt_overflow,
  output logic [WIDTH-1:0]       wb_valid,
  output logic [WIDTH*TAG_W-1:0] wb_tag
);
  localparam int ROW_W = DEPTH*CNT_W;

  logic [(NREQ+1)*ROW_W-1:0] cnt_chain;
  logic [NREQ-1:0]           hit, miss;
  logic [NREQ*CYC_W-1:0]     cyc;
  logic [NREQ*PORT_W-1:0]    port;
  logic [ROW_W-1:0]          view_cnt;

  assign cnt_chain[0 +: ROW_W] = view_cnt;

  // One search per lane; each lane sees the counts left by lower lanes.
  genvar i;
  generate
    for (i = 0; i < NREQ; i++) begin : g_lane
      wbs_find #(.WIDTH(WIDTH), .DEPTH(DEPTH), .CNT_W(CNT_W),
                 .CYC_W(CYC_W), .PORT_W(PORT_W)) u_find (
        .req     (req_valid[i]),
        .cnt_in  (cnt_chain[i*ROW_W +: ROW_W]),
        .hit     (hit[i]),
        .miss    (miss[i]),
        .cyc     (cyc[i*CYC_W +: CYC_W]),
        .port    (port[i*PORT_W +: PORT_W]),
        .cnt_out (cnt_chain[(i+1)*ROW_W +: ROW_W])
      );
    end
  endgenerate

  wbs_window #(.WIDTH(WIDTH), .DEPTH(DEPTH), .NREQ(NREQ), .TAG_W(TAG_W),
               .CNT_W(CNT_W), .CYC_W(CYC_W), .PORT_W(PORT_W)) u_win (
    .clk      (clk),
    .rst      (rst),
    .cnt_fin  (cnt_chain[NREQ*ROW_W +: ROW_W]),
    .wr_en    (hit),
    .wr_cyc   (cyc),
    .wr_port  (port),
    .wr_tag   (req_tag),
    .view_cnt (view_cnt),
    .wb_valid (wb_valid),
    .wb_tag   (wb_tag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_valid    <= '0;
      gnt_overflow <= '0;
      gnt_cycle    <= '0;
      gnt_port     <= '0;
    end else begin
      gnt_valid    <= hit;
      gnt_overflow <= miss;
      gnt_cycle    <= cyc;
      gnt_port     <= port;
    end
  end

  AST_GNT_EXCL: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid & gnt_overflow) == '0); // R6
  AST_GNT_REQ: assert property (@(posedge clk) disable iff (rst)
    ((gnt_valid | gnt_overflow) & ~$past(req_valid)) == '0); // R8
  AST_WB_PREFIX: assert property (@(posedge clk) disable iff (rst)
    (wb_valid & (wb_valid + 1'b1)) == '0); // R7
endmodule

// File: tb/wb_slot_alloc_tb.sv
`timescale 1ns/1ps
module wb_slot_alloc_tb;
  localparam int WIDTH = 2, DEPTH = 4, NREQ = 3, TAG_W = 8;
  localparam int CYC_W = 2, PORT_W = 1;

  logic clk = 0, rst = 1;
  logic [NREQ-1:0]        req_valid = '0;
  logic [NREQ*TAG_W-1:0]  req_tag = '0;
  logic [NREQ-1:0]        gnt_valid, gnt_overflow;
  logic [NREQ*CYC_W-1:0]  gnt_cycle;
  logic [NREQ*PORT_W-1:0] gnt_port;
  logic [WIDTH-1:0]       wb_valid;
  logic [WIDTH*TAG_W-1:0] wb_tag;

  int checks = 0, errors = 0;
  bit done = 0;
  int mcnt [DEPTH];
  logic [TAG_W-1:0] mtag [DEPTH][WIDTH];
  logic [TAG_W-1:0] next_tag = 8'd1;

  always #2.5 clk = ~clk;

  wb_slot_alloc #(.WIDTH(WIDTH), .DEPTH(DEPTH), .NREQ(NREQ), .TAG_W(TAG_W)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_tag(req_tag),
    .gnt_valid(gnt_valid), .gnt_cycle(gnt_cycle), .gnt_port(gnt_port),
    .gnt_overflow(gnt_overflow), .wb_valid(wb_valid), .wb_tag(wb_tag));

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic void model_clear();
    for (int k = 0; k < DEPTH; k++) begin
      mcnt[k] = 0;
      for (int p = 0; p < WIDTH; p++) mtag[k][p] = '0;
    end
  endfunction

  task automatic check_wb();
    for (int p = 0; p < WIDTH; p++) begin
      chk($sformatf("R7 wb_valid[%0d]", p), int'(wb_valid[p]), (p < mcnt[0]) ? 1 : 0);
      if (p < mcnt[0])
        chk($sformatf("R5 wb_tag[%0d]", p), int'(wb_tag[p*TAG_W +: TAG_W]), int'(mtag[0][p]));
      else
        chk($sformatf("R7 idle tag[%0d]", p), int'(wb_tag[p*TAG_W +: TAG_W]), 0);
    end
  endtask

  task automatic step(input logic [NREQ-1:0] v);
    bit eg [NREQ]; bit eo [NREQ]; int ec [NREQ]; int ep [NREQ];
    bit seen; string rq;
    logic [NREQ*TAG_W-1:0] t;
    @(negedge clk);
    for (int i = 0; i < NREQ; i++) begin
      t[i*TAG_W +: TAG_W] = next_tag;
      next_tag = (next_tag == 8'hFF) ? 8'd1 : next_tag + 8'd1;
    end
    req_valid = v; req_tag = t;
    for (int k = 0; k < DEPTH-1; k++) begin
      mcnt[k] = mcnt[k+1];
      for (int p = 0; p < WIDTH; p++) mtag[k][p] = mtag[k+1][p];
    end
    mcnt[DEPTH-1] = 0;
    for (int p = 0; p < WIDTH; p++) mtag[DEPTH-1][p] = '0;
    for (int i = 0; i < NREQ; i++) begin
      eg[i] = 0; eo[i] = 0; ec[i] = 0; ep[i] = 0;
      if (v[i]) begin
        for (int d = 0; d < DEPTH; d++)
          if (!eg[i] && mcnt[d] < WIDTH) begin
            eg[i] = 1; ec[i] = d; ep[i] = mcnt[d];
            mtag[d][mcnt[d]] = t[i*TAG_W +: TAG_W];
            mcnt[d]++;
          end
        eo[i] = !eg[i];
      end
    end
    @(posedge clk); #1;
    seen = 0;
    for (int i = 0; i < NREQ; i++) begin
      if (!v[i]) rq = "R8";
      else if (eo[i]) rq = "R6";
      else if (seen) rq = "R3";
      else if (ep[i] == 0 && ec[i] > 0) rq = "R4";
      else rq = "R2";
      chk($sformatf("%s lane%0d valid", rq, i), int'(gnt_valid[i]), int'(eg[i]));
      chk($sformatf("%s lane%0d overflow", rq, i), int'(gnt_overflow[i]), int'(eo[i]));
      if (eg[i]) begin
        chk($sformatf("%s lane%0d cycle", rq, i), int'(gnt_cycle[i*CYC_W +: CYC_W]), ec[i]);
        chk($sformatf("%s lane%0d port", rq, i), int'(gnt_port[i*PORT_W +: PORT_W]), ep[i]);
      end
      if (v[i]) seen = 1;
    end
    req_valid = '0;
    check_wb();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; req_valid = '0;
    model_clear();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 gnt_valid in reset", int'(gnt_valid), 0);
    chk("R1 overflow in reset", int'(gnt_overflow), 0);
    chk("R1 wb_valid in reset", int'(wb_valid), 0);
    @(negedge clk);
    rst = 0;
    @(posedge clk); #1;
    chk("R1 wb_valid after release", int'(wb_valid), 0);
    chk("R1 gnt_valid after release", int'(gnt_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    model_clear();
    do_reset();
    step(3'b001);           // R2 lone request into empty window
    step(3'b000);
    step(3'b000);
    step(3'b111);           // R3/R4 burst spills into the next cycle
    step(3'b101);           // R8 middle lane idle
    repeat (6) step(3'b111); // R6 flood until overflow
    repeat (DEPTH) step(3'b000);
    chk("R9 window drained", int'(wb_valid), 0);
    repeat (3) step(3'b111);
    do_reset();             // R1 reset with a loaded window
    for (int n = 0; n < 400; n++) begin
      logic [NREQ-1:0] m;
      m = NREQ'($urandom);
      if (($urandom % 4) == 0) m = '1;
      step(m);
    end
    repeat (DEPTH) step(3'b000);
    chk("R9 window drained at end", int'(wb_valid), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule